// File: doc/BRIEF.md
# SPI Frame Status and Event Flags

This block sits beside an SPI shift engine and turns chip-select activity and receive-queue occupancy into a 16-bit status word and one interrupt request. It brings the raw chip-select line into the clock domain through a two-flop synchronizer. It then detects the start and end of a frame from the falling and rising edges of that line. It also detects a frame that is cut off in the middle of a byte.

Three of the status bits are sticky event flags. A read of the status word clears them. While any of them is set, the interrupt request stays high. A fourth bit is a live comparison between the receive-queue fill level and a 2-bit threshold. A master enable stops all event capture and holds the sticky flags at zero.

Top module: `spi_frame_status`

## Requirements
- R1: After a synchronous reset, `stat_word` is 0x0000 and `irq` is 0. The synchronizer stages reset to the idle level 1, so releasing reset with `cs_n` high creates no edge.
- R2: When `enable`, `cont_mode` and `cs_irq_en` are all 1, a rising edge on `cs_n` sets bit 14 (frame end). The bit is visible after the third rising clock edge that follows the input change.
- R3: Under the same three conditions, a falling edge on `cs_n` sets bit 13 (frame start), with the same latency as in R2.
- R4: When `cont_mode` or `cs_irq_en` is 0, edges on `cs_n` leave bits 14 and 13 at 0.
- R5: When `enable` is 1, a rising edge on `cs_n` sets bit 12 (abort) if `bit_cnt` is non-zero and `byte_done` is 0 in the cycle the edge is seen. If `bit_cnt` is 0, or if `byte_done` is 1, bit 12 stays 0.
- R6: Bits 14, 13 and 12 hold their value until `stat_rd` is 1 for a cycle. They read 0 from the next clock edge on.
- R7: When a set event for a flag falls in the same cycle as `stat_rd`, the flag ends up 1 after that edge.
- R8: `irq` is 1 exactly when at least one of bits 14, 13 and 12 is 1.
- R9: Bit 11 is 1 while `rx_level` is greater than `rx_thresh`, and 0 otherwise. It follows the inputs in the same cycle, with no stickiness.
- R10: Bit 15 and bits 10 to 0 of `stat_word` always read 0.
- R11: While `enable` is 0, bits 14, 13 and 12 are 0 from the next clock edge on. Edges seen while `enable` is 0 set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable |
| cont_mode | input | 1 | Continuous-transfer mode select |
| cs_irq_en | input | 1 | Enables the chip-select edge flags |
| cs_n | input | 1 | Raw chip-select line, active low |
| bit_cnt | input | 3 | Bits of the current byte already shifted |
| byte_done | input | 1 | Byte-complete strobe from the shifter |
| rx_level | input | 4 | Receive queue occupancy |
| rx_thresh | input | 2 | Excess threshold |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| stat_word | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the fixed-zero bits, the link between `irq` and the flags, that a flag holds until a read, that a read clears it, that a disable clears it, and that the excess bit agrees with the occupancy at its extremes. Only the bench scenarios show the rest, because each needs a chosen sequence of stimulus. These are the three-edge latency from a pin change to a flag, the gating of the edge flags by mode and enable, the abort rule for a non-zero bit count, and the rule that a set wins over a read that lands in the same cycle.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int STAT_W     = 16;
    localparam int POS_END    = 14;
    localparam int POS_START  = 13;
    localparam int POS_ABORT  = 12;
    localparam int POS_EXCESS = 11;

    typedef struct packed {
        logic frame_end;
        logic frame_start;
        logic abort;
    } evt_flags_t;

    localparam evt_flags_t FLAGS_NONE = '{frame_end: 1'b0, frame_start: 1'b0, abort: 1'b0};

    function automatic logic [STAT_W-1:0] pack_status(evt_flags_t f, logic excess);
        logic [STAT_W-1:0] w;
        w = '0;
        w[POS_END]    = f.frame_end;
        w[POS_START]  = f.frame_start;
        w[POS_ABORT]  = f.abort;
        w[POS_EXCESS] = excess;
        return w;
    endfunction

    function automatic logic any_flag(evt_flags_t f);
        return f.frame_end | f.frame_start | f.abort;
    endfunction
endpackage

// File: rtl/spi_cs_edge.sv
module spi_cs_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cs_async,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= cs_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[LAST-1:0], cs_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[LAST];
    end

    always_comb begin
        rise = enable &  chain[LAST] & ~prev;
        fall = enable & ~chain[LAST] &  prev;
    end
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
    import spi_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  evt_flags_t set_evt,
    input  logic       rd_clr,
    output evt_flags_t flags
);
    evt_flags_t nxt;

    always_comb begin
        if (!enable) begin
            nxt = FLAGS_NONE;
        end else begin
            nxt = rd_clr ? FLAGS_NONE : flags;
            nxt = nxt | set_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= FLAGS_NONE;
        else     flags <= nxt;
    end
endmodule

// File: rtl/spi_rx_excess.sv
module spi_rx_excess #(
    parameter int LVL_W = 4,
    parameter int TH_W  = 2
) (
    input  logic [LVL_W-1:0] level,
    input  logic [TH_W-1:0]  thresh,
    output logic             excess
);
    localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;

    logic [CMP_W-1:0] lvl_x, th_x;

    always_comb begin
        lvl_x  = CMP_W'(level);
        th_x   = CMP_W'(thresh);
        excess = lvl_x > th_x;
    end
endmodule

// File: rtl/spi_frame_status.sv
module spi_frame_status
    import spi_stat_pkg::*;
#(
    parameter int BIT_W       = 3,
    parameter int LVL_W       = 4,
    parameter int TH_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cont_mode,
    input  logic              cs_irq_en,
    input  logic              cs_n,
    input  logic [BIT_W-1:0]  bit_cnt,
    input  logic              byte_done,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [TH_W-1:0]   rx_thresh,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq
);
    logic       cs_rise, cs_fall, excess, edge_ok, partial;
    evt_flags_t set_evt, flags;

    spi_cs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .enable(enable), .cs_async(cs_n),
        .rise(cs_rise), .fall(cs_fall)
    );

    always_comb begin
        edge_ok             = cont_mode & cs_irq_en;
        partial             = (bit_cnt != '0) & ~byte_done;
        set_evt.frame_end   = cs_rise & edge_ok;
        set_evt.frame_start = cs_fall & edge_ok;
        set_evt.abort       = cs_rise & partial;
    end

    spi_evt_flags u_flags (
        .clk(clk), .rst(rst), .enable(enable), .set_evt(set_evt),
        .rd_clr(stat_rd), .flags(flags)
    );

    spi_rx_excess #(.LVL_W(LVL_W), .TH_W(TH_W)) u_excess (
        .level(rx_level), .thresh(rx_thresh), .excess(excess)
    );

    always_comb begin
        stat_word = pack_status(flags, excess);
        irq       = any_flag(flags);
    end
endmodule

// File: rtl/spi_frame_status_chk.sv
module spi_frame_status_chk #(
    parameter int LVL_W = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        cont_mode,
    input logic        cs_irq_en,
    input logic        stat_rd,
    input logic        rise_evt,
    input logic        fall_evt,
    input logic [LVL_W-1:0] rx_level,
    input logic [15:0] stat_word,
    input logic        irq
);
    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
        (stat_word[15] == 1'b0) && (stat_word[10:0] == '0)); // R10
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        irq == (stat_word[14:12] != 3'b000)); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rise_evt && !fall_evt) |=> (stat_word[14:12] == 3'b000)); // R6
    AST_END_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (enable && !stat_rd && stat_word[14]) |=> stat_word[14]); // R6
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (stat_word[14:12] == 3'b000)); // R11
    AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && enable && cont_mode && cs_irq_en) |=> stat_word[13]); // R3
    AST_EMPTY_NO_EXCESS: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> !stat_word[11]); // R9
    AST_FULL_EXCESS: assert property (@(posedge clk) disable iff (rst)
        (rx_level > LVL_W'(3)) |-> stat_word[11]); // R9
endmodule

bind spi_frame_status spi_frame_status_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .cont_mode(cont_mode),
    .cs_irq_en(cs_irq_en), .stat_rd(stat_rd), .rise_evt(cs_rise),
    .fall_evt(cs_fall), .rx_level(rx_level), .stat_word(stat_word), .irq(irq)
);

// File: tb/sim_spi_frame_status.sv
`timescale 1ns/1ps
module sim_spi_frame_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, cont_mode = 1'b0, cs_irq_en = 1'b0;
    logic        cs_n = 1'b1, byte_done = 1'b0, stat_rd = 1'b0;
    logic [2:0]  bit_cnt = '0;
    logic [3:0]  rx_level = '0;
    logic [1:0]  rx_thresh = '0;
    logic [15:0] stat_word;
    logic        irq;
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_frame_status u0 (
        .clk(clk), .rst(rst), .enable(enable), .cont_mode(cont_mode),
        .cs_irq_en(cs_irq_en), .cs_n(cs_n), .bit_cnt(bit_cnt),
        .byte_done(byte_done), .rx_level(rx_level), .rx_thresh(rx_thresh),
        .stat_rd(stat_rd), .stat_word(stat_word), .irq(irq)
    );

    function automatic logic exp_excess(logic [3:0] l, logic [1:0] t);
        return l > {2'b00, t};
    endfunction
    function automatic logic exp_abort(logic [2:0] b, logic d);
        return (b != 3'd0) && !d;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_read();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            report();
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        tick(3);
        rst = 1'b0;
        #0;
        chk("R1 word", stat_word, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        enable = 1; cont_mode = 1; cs_irq_en = 1;
        tick(3);
        chk("R1 no spurious edge", stat_word, 16'h0000);

        // frame start
        cs_n = 0; tick(2);
        chk("R3 not yet", stat_word[15:12], 4'h0);
        tick();
        chk("R3 start", stat_word[15:12], 4'b0010);
        chk("R8 irq", {15'd0, irq}, 16'd1);
        tick(4);
        chk("R6 held", stat_word[15:12], 4'b0010);
        stat_rd = 1; #0;
        chk("R6 read value", stat_word[15:12], 4'b0010);
        tick(); stat_rd = 0;
        chk("R6 cleared", stat_word[15:12], 4'h0);
        chk("R8 irq low", {15'd0, irq}, 16'd0);

        // frame end, whole byte
        cs_n = 1; tick(3);
        chk("R2 end", stat_word[15:12], 4'b0100);
        chk("R5 no abort at bit 0", {15'd0, stat_word[12]}, 16'd0);
        do_read();

        // abort mid-byte with mode gated off
        cont_mode = 0; bit_cnt = 3'd5;
        cs_n = 0; tick(3);
        chk("R4 no start", stat_word[15:12], 4'h0);
        cs_n = 1; tick(3);
        chk("R5 abort only", stat_word[15:12], 4'b0001);
        chk("R8 irq abort", {15'd0, irq}, 16'd1);
        do_read();
        bit_cnt = 0;

        // set wins over read in the same cycle
        cont_mode = 1; cs_n = 0; tick(2);
        stat_rd = 1; tick(); stat_rd = 0;
        chk("R7 set wins", stat_word[15:12], 4'b0010);
        do_read();

        // disable
        cs_n = 1; tick(3);
        enable = 0; tick();
        chk("R11 cleared", stat_word[15:12], 4'h0);
        cs_n = 0; tick(4);
        chk("R11 no event", stat_word[15:12], 4'h0);
        cs_n = 1; tick(4);
        enable = 1; tick(2);
        chk("R11 reenable quiet", stat_word[15:12], 4'h0);

        // random edge scenarios
        for (int k = 0; k < 40; k++) begin
            logic c, e, d;
            logic [2:0] b;
            c = 1'($urandom); e = 1'($urandom);
            b = 3'($urandom); d = 1'($urandom);
            if (k % 4 == 0) b = 0;
            cont_mode = c; cs_irq_en = e; bit_cnt = b; byte_done = d;
            cs_n = 0; tick(3);
            chk("R3/R4 rand start", stat_word[15:12], {1'b0, 1'b0, c & e, 1'b0});
            do_read();
            cs_n = 1; tick(3);
            chk("R2/R5 rand end", stat_word[15:12], {1'b0, c & e, 1'b0, exp_abort(b, d)});
            chk("R8 rand irq", {15'd0, irq}, {15'd0, (c & e) | exp_abort(b, d)});
            do_read();
            chk("R6 rand clear", stat_word[15:12], 4'h0);
        end
        byte_done = 0; bit_cnt = 0;

        // live excess comparison
        for (int k = 0; k < 60; k++) begin
            rx_level = 4'($urandom); rx_thresh = 2'($urandom);
            if (k < 4) begin rx_thresh = 2'(k); rx_level = 4'(k); end
            #1;
            chk("R9 excess", {15'd0, stat_word[11]}, {15'd0, exp_excess(rx_level, rx_thresh)});
            chk("R10 zero bits", {stat_word[15], stat_word[10:0]}, 12'h000);
            tick();
        end
        rx_thresh = 2'd3; rx_level = 4'd4; #1;
        chk("R9 above max thresh", {15'd0, stat_word[11]}, 16'd1);
        rx_level = 4'd3; #1;
        chk("R9 at thresh", {15'd0, stat_word[11]}, 16'd0);
        report();
    end
endmodule